// File: doc/BRIEF.md
# ISA Lane-Sizing Cycle Sequencer

This block sits between a host access port and an ISA-style stackable expansion bus. The bus has an 8-bit low lane and an 8-bit high lane. The host asks for a byte, 16-bit or 32-bit read or write, and states whether the target port is 8 or 16 bits wide. When the access is wider than the port, the sequencer plays it out as several narrow bus beats.

Writes become back-to-back write strobes. Each strobe has its own address, and a short idle gap separates one strobe from the next. A read is a single read strobe that is held low for several segments. The address steps at each segment boundary, and the lane data is sampled at the end of every segment. The block drives the address, the active-low high-byte-enable, the write lanes and their output enable. It collects read bytes into a little-endian host word, which it returns with a one-cycle done pulse.

The lengths of strobes, gaps and segments are parameters given in clock counts. A request that cannot be run produces a one-cycle error pulse, and no bus activity takes place.

Top module: `busz_seq`

## Requirements
- R1: After reset, `reqReady` is high, `busRdN`, `busWrN` and `hiEnN` are high, and `done`, `err` and `dataOe` are low. A request is accepted only on a clock edge where `reqValid` and `reqReady` are both high. `reqValid` pulses while the block is busy start nothing.
- R2: Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit. On an 8-bit port (`reqWide`=0), a write of 1, 2 or 4 bytes gives 1, 2 or 4 write strobes. Strobe k uses address `reqAddr`+k, puts `reqWdata[8k+7:8k]` on `dataOut[7:0]` with `dataOut[15:8]`=0, and holds `hiEnN` high.
- R3: On a 16-bit port, a byte write is one strobe at `reqAddr` with `hiEnN` = NOT `reqAddr[0]`. The byte goes on `dataOut[7:0]` for an even address and on `dataOut[15:8]` for an odd one; the unused lane is 0.
- R4: On a 16-bit port, a 16-bit write is one strobe and a 32-bit write is two strobes. Strobe k uses address `reqAddr`+2k, puts `reqWdata[16k+15:16k]` on `dataOut`, and holds `hiEnN` low.
- R5: Each write strobe lasts exactly WR_LEN cycles, with the address held steady. Consecutive strobes of one access are separated by exactly WR_GAP cycles with `busWrN` high.
- R6: A read is one continuous `busRdN` low period of N×RD_SEG cycles. N is the beat count from R2 to R4. The address starts at `reqAddr` and steps N-1 times, by +1 on an 8-bit port or +2 on a 16-bit port, each step on an RD_SEG boundary.
- R7: `hiEnN` is low for the whole of every read strobe, whatever the size.
- R8: Read data is sampled in the last cycle of each segment. On an 8-bit port, segment k fills byte k from `dataIn[7:0]`. On a 16-bit port, a byte read takes `dataIn[7:0]` for an even address and `dataIn[15:8]` for an odd one, and segment k of a wider read fills half k from `dataIn`. Unfilled upper bytes are 0. `done` is a one-cycle pulse in the cycle after the last strobe cycle, and `rdData` is valid with it.
- R9: A request is flagged with a one-cycle `err` pulse, one cycle after acceptance, with no strobe and no `done`, in these cases: size code 3; a 16-bit access to an 8-bit port at an odd address; a 32-bit access whose address bits [1:0] are not 0.
- R10: `dataOe` is high only while `busWrN` is low. It is low throughout reads. `busRdN` and `busWrN` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| reqWide | input | 1 | Target port is 16 bits wide |
| reqAddr | input | ADDR_W | Start byte address |
| reqWdata | input | 32 | Write data, least significant byte at lowest address |
| done | output | 1 | Access complete pulse |
| err | output | 1 | Rejected request pulse |
| rdData | output | 32 | Assembled read word |
| busAddr | output | ADDR_W | Bus address |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| hiEnN | output | 1 | High-byte enable, active low |
| dataOut | output | 16 | Write lanes {high, low} |
| dataOe | output | 1 | Write lanes drive enable |
| dataIn | input | 16 | Read lanes {high, low} |

## Verification
The hardest situation to reach from the ports is a multi-segment read. Here the address must change under a strobe that stays low, and each lane must be sampled only at the segment end. The bench's target model returns data computed from the current bus address, with a poison value on the unused high lane of an 8-bit port. As a result, a sample taken in the wrong segment or from the wrong lane changes the assembled word. A second hard case is a request that arrives while an access is in flight. Directed transactions hold `reqValid` high with different contents during the first strobe, then confirm that the beat list is unchanged and that no further access follows.

// File: rtl/busz_pkg.sv
package busz_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_SHORT = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_RSVD  = 2'd3
  } accSize_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // latch a new request
    logic step;     // advance to next beat (address and lane index)
    logic capture;  // sample read lanes for current beat
    logic drive;    // a strobe is active
  } dpCtl_t;

  function automatic logic [2:0] beatsFor(accSize_t sz, logic wide);
    case (sz)
      SZ_BYTE:  return 3'd1;
      SZ_SHORT: return wide ? 3'd1 : 3'd2;
      SZ_LONG:  return wide ? 3'd2 : 3'd4;
      default:  return 3'd1;
    endcase
  endfunction

  function automatic logic reqIllegal(accSize_t sz, logic wide, logic [1:0] lo);
    case (sz)
      SZ_BYTE:  return 1'b0;
      SZ_SHORT: return !wide && lo[0];
      SZ_LONG:  return lo != 2'b00;
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/busz_ctrl.sv
module busz_ctrl
  import busz_pkg::*;
#(
  parameter int WR_LEN = 56,
  parameter int WR_GAP = 4,
  parameter int RD_SEG = 54
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  accSize_t reqSize,
  input  logic     reqWide,
  input  logic [1:0] reqAddrLo,
  output logic     reqReady,
  output logic     busRdN,
  output logic     busWrN,
  output logic     dataOe,
  output logic     done,
  output logic     err,
  output dpCtl_t   ctl
);

  localparam int LEN_MAX = (WR_LEN > RD_SEG) ? WR_LEN : RD_SEG;
  localparam int ALL_MAX = (LEN_MAX > WR_GAP) ? LEN_MAX : WR_GAP;
  localparam int CNT_W   = $clog2(ALL_MAX + 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_LEN - 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_SEG - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(WR_GAP - 1);

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_GAP} state_t;

  state_t           stQ;
  logic [CNT_W-1:0] cntQ;
  logic [2:0]       leftQ;
  logic             isWrQ;
  logic             doneQ;
  logic             errQ;

  logic accept, bad, segEnd, lastBeat;

  assign accept   = (stQ == S_IDLE) && reqValid;
  assign bad      = reqIllegal(reqSize, reqWide, reqAddrLo);
  assign segEnd   = (stQ == S_STROBE) && (cntQ == (isWrQ ? WR_LAST : RD_LAST));
  assign lastBeat = (leftQ == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stQ   <= S_IDLE;
      cntQ  <= '0;
      leftQ <= '0;
      isWrQ <= 1'b0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      case (stQ)
        S_IDLE: begin
          if (accept) begin
            if (bad) begin
              errQ <= 1'b1;
            end else begin
              stQ   <= S_STROBE;
              cntQ  <= '0;
              leftQ <= beatsFor(reqSize, reqWide);
              isWrQ <= reqWrite;
            end
          end
        end
        S_STROBE: begin
          if (segEnd) begin
            cntQ  <= '0;
            leftQ <= leftQ - 3'd1;
            if (lastBeat) begin
              stQ   <= S_IDLE;
              doneQ <= 1'b1;
            end else if (isWrQ) begin
              stQ <= S_GAP;
            end
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        S_GAP: begin
          if (cntQ == GAP_LAST) begin
            cntQ <= '0;
            stQ  <= S_STROBE;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        default: stQ <= S_IDLE;
      endcase
    end
  end

  assign ctl.load    = accept && !bad;
  assign ctl.step    = segEnd && !lastBeat;
  assign ctl.capture = segEnd && !isWrQ;
  assign ctl.drive   = (stQ == S_STROBE);

  assign reqReady = (stQ == S_IDLE);
  assign busRdN   = !((stQ == S_STROBE) && !isWrQ);
  assign busWrN   = !((stQ == S_STROBE) && isWrQ);
  assign dataOe   = (stQ == S_STROBE) && isWrQ;
  assign done     = doneQ;
  assign err      = errQ;

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!busRdN && !busWrN));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (busRdN && busWrN && !done && $past(reqReady)));

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busRdN || !busWrN) |-> !reqReady);

endmodule

// File: rtl/busz_dp.sv
module busz_dp
  import busz_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  accSize_t          reqSize,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [15:0]       dataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       dataOut,
  output logic              hiEnN,
  output logic [31:0]       rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [31:0]       wdQ;
  logic [31:0]       rdQ;
  accSize_t          szQ;
  logic              wideQ;
  logic              wrQ;
  logic [1:0]        idxQ;

  logic [ADDR_W-1:0] stepAmt;
  logic [31:0]       wdShift;
  logic [15:0]       lanes;
  logic              hiRaw;

  assign stepAmt = {{(ADDR_W-2){1'b0}}, wideQ, !wideQ};
  assign wdShift = wdQ >> {idxQ, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ <= '0;
      wdQ   <= '0;
      rdQ   <= '0;
      szQ   <= SZ_BYTE;
      wideQ <= 1'b0;
      wrQ   <= 1'b0;
      idxQ  <= '0;
    end else begin
      if (ctl.load) begin
        addrQ <= reqAddr;
        wdQ   <= reqWdata;
        rdQ   <= '0;
        szQ   <= reqSize;
        wideQ <= reqWide;
        wrQ   <= reqWrite;
        idxQ  <= '0;
      end else begin
        if (ctl.capture) begin
          if (!wideQ)
            rdQ[{idxQ, 3'b000} +: 8] <= dataIn[7:0];
          else if (szQ == SZ_BYTE)
            rdQ[7:0] <= addrQ[0] ? dataIn[15:8] : dataIn[7:0];
          else
            rdQ[{idxQ[0], 4'b0000} +: 16] <= dataIn;
        end
        if (ctl.step) begin
          addrQ <= addrQ + stepAmt;
          idxQ  <= idxQ + 2'd1;
        end
      end
    end
  end

  // lane steering for writes
  always_comb begin
    if (!wideQ) begin
      lanes = {8'h00, wdShift[7:0]};
      hiRaw = 1'b1;
    end else if (szQ == SZ_BYTE) begin
      lanes = addrQ[0] ? {wdQ[7:0], 8'h00} : {8'h00, wdQ[7:0]};
      hiRaw = !addrQ[0];
    end else begin
      lanes = idxQ[0] ? wdQ[31:16] : wdQ[15:0];
      hiRaw = 1'b0;
    end
  end

  assign busAddr = addrQ;
  assign dataOut = wrQ ? lanes : 16'h0000;
  assign hiEnN   = ctl.drive ? (wrQ ? hiRaw : 1'b0) : 1'b1;
  assign rdData  = rdQ;

endmodule

// File: rtl/busz_seq.sv
module busz_seq
  import busz_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WR_LEN = 56,
  parameter int WR_GAP = 4,
  parameter int RD_SEG = 54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRdN,
  output logic              busWrN,
  output logic              hiEnN,
  output logic [15:0]       dataOut,
  output logic              dataOe,
  input  logic [15:0]       dataIn
);

  dpCtl_t   ctl;
  accSize_t sz;

  assign sz = accSize_t'(reqSize);

  busz_ctrl #(.WR_LEN(WR_LEN), .WR_GAP(WR_GAP), .RD_SEG(RD_SEG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(sz), .reqWide(reqWide), .reqAddrLo(reqAddr[1:0]),
    .reqReady(reqReady), .busRdN(busRdN), .busWrN(busWrN), .dataOe(dataOe),
    .done(done), .err(err), .ctl(ctl)
  );

  busz_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqWrite(reqWrite), .reqSize(sz),
    .reqWide(reqWide), .reqAddr(reqAddr), .reqWdata(reqWdata), .dataIn(dataIn),
    .busAddr(busAddr), .dataOut(dataOut), .hiEnN(hiEnN), .rdData(rdData)
  );

  // R7
  read_hien_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busRdN |-> !hiEnN);

  // R5
  wr_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busWrN && $past(!busWrN)) |-> $stable(busAddr));

endmodule

// File: tb/busz_seq_tb.sv
module busz_seq_tb;

  localparam int ADDR_W = 16;
  localparam int WR_LEN = 5;
  localparam int WR_GAP = 2;
  localparam int RD_SEG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWide = 1'b0;
  logic [1:0] reqSize = 2'd0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic reqReady, done, err, busRdN, busWrN, hiEnN, dataOe;
  logic [31:0] rdData;
  logic [15:0] busAddr, dataOut, dataIn;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  busz_seq #(.ADDR_W(ADDR_W), .WR_LEN(WR_LEN), .WR_GAP(WR_GAP), .RD_SEG(RD_SEG)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqSize(reqSize), .reqWide(reqWide), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .done(done), .err(err), .rdData(rdData),
    .busAddr(busAddr), .busRdN(busRdN), .busWrN(busWrN), .hiEnN(hiEnN),
    .dataOut(dataOut), .dataOe(dataOe), .dataIn(dataIn)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29 + 8'h3C;
    return m ^ a[15:8];
  endfunction

  // target model: data follows the current bus address
  always_comb begin
    if (reqWide) dataIn = {mb(busAddr | 16'h0001), mb(busAddr & 16'hFFFE)};
    else         dataIn = {8'hEE, mb(busAddr)};
  end

  // bus monitor
  logic [15:0] bAddr [8];
  logic [15:0] bData [8];
  logic        bHi   [8];
  logic        bOe   [8];
  int bLen [8];
  int bGap [8];
  int nW, gapCnt, wrMove, rdLen, rdSteps, rdStepBad, rdHiBad, rdOeBad;
  logic [15:0] rdAddr0, prevAddr;
  logic prevWr, prevRd;

  task automatic clearMon();
    nW = 0; gapCnt = 0; wrMove = 0; rdLen = 0; rdSteps = 0;
    rdStepBad = 0; rdHiBad = 0; rdOeBad = 0; prevWr = 1'b1; prevRd = 1'b1;
    rdAddr0 = '0; prevAddr = '0;
    for (int i = 0; i < 8; i++) begin bLen[i] = 0; bGap[i] = 0; end
  endtask

  always @(negedge clk) begin
    if (!busWrN) begin
      if (prevWr) begin
        if (nW < 8) begin
          bAddr[nW] = busAddr; bData[nW] = dataOut; bHi[nW] = hiEnN;
          bOe[nW] = dataOe; bGap[nW] = gapCnt; bLen[nW] = 1;
        end
        nW++;
      end else begin
        if (nW >= 1 && nW <= 8) bLen[nW-1]++;
        if (busAddr != prevAddr) wrMove++;
      end
      gapCnt = 0;
    end else begin
      gapCnt++;
    end
    if (!busRdN) begin
      if (prevRd) rdAddr0 = busAddr;
      else if (busAddr != prevAddr) begin
        rdSteps++;
        if (busAddr != prevAddr + (reqWide ? 16'd2 : 16'd1)) rdStepBad++;
        if (rdLen % RD_SEG != 0) rdStepBad++;
      end
      rdLen++;
      if (hiEnN !== 1'b0) rdHiBad++;
      if (dataOe !== 1'b0) rdOeBad++;
    end
    prevWr = busWrN; prevRd = busRdN; prevAddr = busAddr;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit illegal(input logic [1:0] sz, input bit wide, input logic [15:0] a);
    if (sz == 2'd3) return 1'b1;
    if (sz == 2'd1) return !wide && a[0];
    if (sz == 2'd2) return a[1:0] != 2'b00;
    return 1'b0;
  endfunction

  task automatic runTx(input bit wr, input logic [1:0] sz, input bit wide,
                       input logic [15:0] a, input logic [31:0] wd, input bit poke);
    int nb, n, waitC;
    bit expErr;
    logic [31:0] expRd;
    string tag;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    n  = wide ? ((sz == 2'd0) ? 1 : nb / 2) : nb;
    expErr = illegal(sz, wide, a);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqWide = wide; reqAddr = a; reqWdata = wd;
    @(posedge clk); #1;
    clearMon();
    reqValid = 1'b0;
    if (poke) begin
      // R1: a request while busy must not start anything
      reqValid = 1'b1; reqWrite = !wr; reqSize = 2'd0; reqAddr = ~a; reqWdata = ~wd;
      repeat (3) @(posedge clk);
      #1 reqValid = 1'b0;
    end
    waitC = 0;
    do begin @(negedge clk); waitC++; end while (!done && !err && waitC < 2000);
    chk(waitC < 2000, "R8 completion", waitC, 0);
    if (expErr) begin
      chk(err === 1'b1 && done === 1'b0, "R9 err pulse", {err, done}, 2'b10);
      chk(nW == 0 && rdLen == 0, "R9 no strobe", nW + rdLen, 0);
      chk(waitC == 1, "R9 err timing", waitC, 1);
    end else if (wr) begin
      tag = !wide ? "R2" : (sz == 2'd0) ? "R3" : "R4";
      chk(done === 1'b1 && err === 1'b0, "R8 done", {done, err}, 2'b10);
      chk(nW == n, {tag, " beat count"}, nW, n);
      chk(wrMove == 0, "R5 addr stable", wrMove, 0);
      for (int k = 0; k < n && k < nW; k++) begin
        logic [15:0] eA, eD; logic eH;
        if (!wide) begin
          eA = a + 16'(k); eD = {8'h00, 8'(wd >> (8 * k))}; eH = 1'b1;
        end else if (sz == 2'd0) begin
          eA = a; eD = a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]}; eH = !a[0];
        end else begin
          eA = a + 16'(2 * k); eD = 16'(wd >> (16 * k)); eH = 1'b0;
        end
        chk(bAddr[k] == eA, {tag, " addr"}, bAddr[k], eA);
        chk(bData[k] == eD, {tag, " lanes"}, bData[k], eD);
        chk(bHi[k] == eH, {tag, " hiEnN"}, bHi[k], eH);
        chk(bOe[k] == 1'b1, "R10 oe on write", bOe[k], 1);
        chk(bLen[k] == WR_LEN, "R5 strobe len", bLen[k], WR_LEN);
        if (k > 0) chk(bGap[k] == WR_GAP, "R5 gap", bGap[k], WR_GAP);
      end
    end else begin
      expRd = '0;
      for (int i = 0; i < nb; i++) expRd[8*i +: 8] = mb(a + 16'(i));
      chk(done === 1'b1 && err === 1'b0, "R8 done", {done, err}, 2'b10);
      chk(nW == 0, "R10 no write strobe", nW, 0);
      chk(rdLen == n * RD_SEG, "R6 read len", rdLen, n * RD_SEG);
      chk(rdAddr0 == a, "R6 start addr", rdAddr0, a);
      chk(rdSteps == n - 1 && rdStepBad == 0, "R6 steps", rdSteps, n - 1);
      chk(rdHiBad == 0, "R7 hiEnN low", rdHiBad, 0);
      chk(rdOeBad == 0, "R10 oe off", rdOeBad, 0);
      chk(rdData == expRd, "R8 rdData", rdData, expRd);
    end
    if (poke) begin
      @(negedge clk);
      chk(reqReady && busWrN && busRdN, "R1 busy request ignored",
          {reqReady, busWrN, busRdN}, 3'b111);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clearMon();
    repeat (3) @(negedge clk);
    chk(reqReady === 1'b0 || reqReady === 1'b1, "R1 ready known", reqReady, 1);
    chk(busRdN === 1'b1 && busWrN === 1'b1 && hiEnN === 1'b1, "R1 reset strobes",
        {busRdN, busWrN, hiEnN}, 3'b111);
    chk(done === 1'b0 && err === 1'b0 && dataOe === 1'b0, "R1 reset flags",
        {done, err, dataOe}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1, "R1 ready after reset", reqReady, 1);

    // directed corners
    runTx(1, 2'd0, 0, 16'h1235, 32'hA1B2C3D4, 0);
    runTx(1, 2'd1, 0, 16'h2000, 32'h0000BEEF, 0);
    runTx(1, 2'd2, 0, 16'hFFFC, 32'h89ABCDEF, 1);
    runTx(1, 2'd0, 1, 16'h3000, 32'h0000005A, 0);
    runTx(1, 2'd0, 1, 16'h3001, 32'h000000A5, 0);
    runTx(1, 2'd1, 1, 16'h4002, 32'h00001234, 0);
    runTx(1, 2'd2, 1, 16'h5004, 32'hCAFEF00D, 1);
    runTx(0, 2'd0, 0, 16'h6007, 32'h0, 0);
    runTx(0, 2'd1, 0, 16'hFFFE, 32'h0, 0);
    runTx(0, 2'd2, 0, 16'h7008, 32'h0, 1);
    runTx(0, 2'd0, 1, 16'h8010, 32'h0, 0);
    runTx(0, 2'd0, 1, 16'h8011, 32'h0, 0);
    runTx(0, 2'd1, 1, 16'h9012, 32'h0, 0);
    runTx(0, 2'd2, 1, 16'hA014, 32'h0, 0);
    runTx(1, 2'd3, 1, 16'h0000, 32'h1, 0);
    runTx(0, 2'd1, 0, 16'h0101, 32'h0, 0);
    runTx(1, 2'd2, 1, 16'h0102, 32'h2, 0);
    runTx(0, 2'd2, 0, 16'h0103, 32'h0, 0);

    // constrained random
    for (int it = 0; it < 80; it++) begin
      logic [1:0]  sz;
      logic [15:0] a;
      bit wide, wr;
      sz   = 2'($urandom % 4);
      wide = 1'($urandom % 2);
      wr   = 1'($urandom % 2);
      a    = 16'($urandom);
      if (($urandom % 4) != 0) begin
        if (sz == 2'd1) a[0] = 1'b0;
        if (sz == 2'd2) a[1:0] = 2'b00;
      end
      if (wide && sz == 2'd1) a[0] = 1'b0;
      runTx(wr, sz, wide, a, $urandom, 1'b0);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule